// File: doc/BRIEF.md
# Watchdog Countdown Timer Channel

One channel of a hardware watchdog. A 16-bit down counter decrements once for each tenth-of-second tick strobe delivered from outside. When the counter reaches zero, the channel raises a single-cycle expire event. The event is meant to drive an interrupt or a reset request somewhere else in the chip.

Software reaches the channel through three registers, each with its own strobe:

- **Counter register.** A read returns the current count and reloads the counter from the limit. This read is the keep-alive.
- **Limit register.** A write stores a new limit, loads the counter with it and starts the countdown. A read returns the stored limit.
- **Status register.** Reports whether the channel is running and whether it has expired.

Address decoding, tick generation, interrupt masking and reset generation belong to the surrounding logic.

Top module: `wdog_chan`

## Requirements
- R1: After reset the counter and the limit both hold 1, the status register reads 0 and `expire_o` is low.
- R2: A limit write stores `wr_data_i` as the limit, loads the counter with it, sets the running flag and clears the expired flag, all visible from the next cycle.
- R3: While running, each cycle with `tick_i` high lowers the counter by one. Without a tick, or while not running, the counter holds.
- R4: A counter read returns the current count on `rd_data_o` in the same cycle and reloads the counter from the limit for the next cycle. The reload takes priority over a tick in the same cycle.
- R5: A counter read while the channel is not running reloads the count but leaves the running flag clear.
- R6: A limit read returns the stored limit and leaves the counter unchanged.
- R7: A tick that finds the channel running with a count of 1 or 0 leaves the count at 0. In the next cycle `expire_o` is high for exactly one cycle, the expired flag is set and the running flag is clear.
- R8: The expired flag stays set until the next limit write, whatever ticks or counter reads occur.
- R9: Status reads return the running flag in bit 0 and the expired flag in bit 1; all higher bits read 0.
- R10: A limit write takes priority over a counter read and a tick in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-cycle strobe marking a tenth of a second |
| cnt_rd_i | input | 1 | Counter read strobe (keep-alive) |
| lim_rd_i | input | 1 | Limit read strobe |
| lim_wr_i | input | 1 | Limit write strobe (load and start) |
| stat_rd_i | input | 1 | Status read strobe |
| wr_data_i | input | CNT_W | Write data for the limit register |
| rd_data_o | output | CNT_W | Read data of the strobed register, 0 when no read strobe is high |
| expire_o | output | 1 | One-cycle expire event |

## Verification
The checks assume that at most one read strobe is high in any cycle, because the read mux is only defined for one-hot selection. The stimulus drives every register access through a single task that raises one read strobe at a time. The checks also assume that `tick_i` and the strobes change only between clock edges. The stimulus does combine a limit write, a counter read and a tick in one cycle, to exercise priority without breaking the one-read rule.

// File: rtl/wdog_chan_pkg.sv
package wdog_chan_pkg;
   localparam int ST_RUN_BIT = 0;
   localparam int ST_EXP_BIT = 1;
   localparam int ST_FLAGS   = 2;
endpackage

// File: rtl/wdog_chan_limit.sv
module wdog_chan_limit #(
   parameter int CNT_W   = 16,
   parameter int RST_VAL = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_i,
   input  logic [CNT_W-1:0] wr_data_i,
   output logic [CNT_W-1:0] limit_o
);
   always_ff @(posedge clk) begin
      if (!rst_n)    limit_o <= CNT_W'(RST_VAL);
      else if (wr_i) limit_o <= wr_data_i;
   end
endmodule

// File: rtl/wdog_chan_counter.sv
module wdog_chan_counter #(
   parameter int CNT_W   = 16,
   parameter int RST_VAL = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [CNT_W-1:0] load_val_i,
   input  logic             reload_i,
   input  logic [CNT_W-1:0] reload_val_i,
   input  logic             tick_i,
   input  logic             run_i,
   output logic [CNT_W-1:0] count_o,
   output logic             zero_hit_o
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic step;
   assign step       = tick_i && run_i && !load_i && !reload_i;
   assign zero_hit_o = step && (count_o <= ONE);

   always_ff @(posedge clk) begin
      if (!rst_n)                 count_o <= CNT_W'(RST_VAL);
      else if (load_i)            count_o <= load_val_i;
      else if (reload_i)          count_o <= reload_val_i;
      else if (step && count_o != '0) count_o <= count_o - ONE;
   end
endmodule

// File: rtl/wdog_chan_status.sv
module wdog_chan_status (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   input  logic zero_hit_i,
   output logic run_o,
   output logic exp_o,
   output logic expire_o
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_o    <= 1'b0;
         exp_o    <= 1'b0;
         expire_o <= 1'b0;
      end else if (start_i) begin
         run_o    <= 1'b1;
         exp_o    <= 1'b0;
         expire_o <= 1'b0;
      end else if (zero_hit_i) begin
         run_o    <= 1'b0;
         exp_o    <= 1'b1;
         expire_o <= 1'b1;
      end else begin
         expire_o <= 1'b0;
      end
   end
endmodule

// File: rtl/wdog_chan_rdmux.sv
module wdog_chan_rdmux
   import wdog_chan_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             cnt_sel_i,
   input  logic             lim_sel_i,
   input  logic             stat_sel_i,
   input  logic [CNT_W-1:0] count_i,
   input  logic [CNT_W-1:0] limit_i,
   input  logic             run_i,
   input  logic             exp_i,
   output logic [CNT_W-1:0] rd_data_o
);
   logic [CNT_W-1:0] stat_word;

   generate
      if (CNT_W > ST_FLAGS) begin : g_pad
         assign stat_word = {{(CNT_W-ST_FLAGS){1'b0}}, exp_i, run_i};
      end else begin : g_exact
         assign stat_word = {exp_i, run_i};
      end
   endgenerate

   always_comb begin
      rd_data_o = '0;
      if (cnt_sel_i)       rd_data_o = count_i;
      else if (lim_sel_i)  rd_data_o = limit_i;
      else if (stat_sel_i) rd_data_o = stat_word;
   end
endmodule

// File: rtl/wdog_chan.sv
module wdog_chan #(
   parameter int CNT_W   = 16,
   parameter int RST_VAL = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic             cnt_rd_i,
   input  logic             lim_rd_i,
   input  logic             lim_wr_i,
   input  logic             stat_rd_i,
   input  logic [CNT_W-1:0] wr_data_i,
   output logic [CNT_W-1:0] rd_data_o,
   output logic             expire_o
);
   localparam longint MAX_VAL = (64'd1 << CNT_W) - 1;

   generate
      if (CNT_W < 2 || CNT_W > 32) begin : g_bad_width
         $error("wdog_chan: CNT_W must lie in 2..32");
      end
      if (RST_VAL < 0 || longint'(RST_VAL) > MAX_VAL) begin : g_bad_rst
         $error("wdog_chan: RST_VAL does not fit in CNT_W bits");
      end
   endgenerate

   logic [CNT_W-1:0] limit_q;
   logic [CNT_W-1:0] count_q;
   logic             run_q;
   logic             exp_q;
   logic             zero_hit;

   wdog_chan_limit #(.CNT_W(CNT_W), .RST_VAL(RST_VAL)) u_limit (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_i      (lim_wr_i),
      .wr_data_i (wr_data_i),
      .limit_o   (limit_q)
   );

   wdog_chan_counter #(.CNT_W(CNT_W), .RST_VAL(RST_VAL)) u_counter (
      .clk          (clk),
      .rst_n        (rst_n),
      .load_i       (lim_wr_i),
      .load_val_i   (wr_data_i),
      .reload_i     (cnt_rd_i),
      .reload_val_i (limit_q),
      .tick_i       (tick_i),
      .run_i        (run_q),
      .count_o      (count_q),
      .zero_hit_o   (zero_hit)
   );

   wdog_chan_status u_status (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (lim_wr_i),
      .zero_hit_i (zero_hit),
      .run_o      (run_q),
      .exp_o      (exp_q),
      .expire_o   (expire_o)
   );

   wdog_chan_rdmux #(.CNT_W(CNT_W)) u_rdmux (
      .cnt_sel_i  (cnt_rd_i),
      .lim_sel_i  (lim_rd_i),
      .stat_sel_i (stat_rd_i),
      .count_i    (count_q),
      .limit_i    (limit_q),
      .run_i      (run_q),
      .exp_i      (exp_q),
      .rd_data_o  (rd_data_o)
   );
endmodule

// File: rtl/wdog_chan_chk.sv
module wdog_chan_chk #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tick_i,
   input logic             cnt_rd_i,
   input logic             lim_wr_i,
   input logic [CNT_W-1:0] wr_data_i,
   input logic             expire_o,
   input logic [CNT_W-1:0] count_i,
   input logic [CNT_W-1:0] limit_i,
   input logic             run_i,
   input logic             exp_i
);
   assert_load_starts_R2: assert property (@(posedge clk) disable iff (!rst_n)
      lim_wr_i |=> (run_i && !exp_i && count_i == $past(wr_data_i) && limit_i == $past(wr_data_i)));

   assert_hold_no_event_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_i && !cnt_rd_i && !lim_wr_i) |=> $stable(count_i));

   assert_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_rd_i && !lim_wr_i) |=> (count_i == $past(limit_i)));

   assert_reload_no_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_rd_i && !lim_wr_i && !run_i) |=> !run_i);

   assert_expire_state_R7: assert property (@(posedge clk) disable iff (!rst_n)
      expire_o |-> (exp_i && !run_i && count_i == '0));

   assert_expire_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
      expire_o |=> !expire_o);

   assert_expired_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (exp_i && !lim_wr_i) |=> exp_i);
endmodule

bind wdog_chan wdog_chan_chk #(.CNT_W(CNT_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .tick_i    (tick_i),
   .cnt_rd_i  (cnt_rd_i),
   .lim_wr_i  (lim_wr_i),
   .wr_data_i (wr_data_i),
   .expire_o  (expire_o),
   .count_i   (count_q),
   .limit_i   (limit_q),
   .run_i     (run_q),
   .exp_i     (exp_q)
);

// File: tb/wdog_chan_test.sv
module wdog_chan_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_i = 1'b0;
   logic        cnt_rd_i = 1'b0;
   logic        lim_rd_i = 1'b0;
   logic        lim_wr_i = 1'b0;
   logic        stat_rd_i = 1'b0;
   logic [15:0] wr_data_i = '0;
   logic [15:0] rd_data_o;
   logic        expire_o;

   int vectors = 0;
   int errors  = 0;
   int pulses  = 0;
   bit prev_exp = 1'b0;
   bit done = 1'b0;

   typedef struct {
      logic [15:0] val;
      string       req;
   } exp_item_t;
   exp_item_t scb[$];

   always #10 clk = ~clk;

   wdog_chan uut (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .cnt_rd_i(cnt_rd_i),
      .lim_rd_i(lim_rd_i), .lim_wr_i(lim_wr_i), .stat_rd_i(stat_rd_i),
      .wr_data_i(wr_data_i), .rd_data_o(rd_data_o), .expire_o(expire_o)
   );

   // monitor: compares read data with scoreboard, tracks expire pulses
   always @(negedge clk) begin
      if (rst_n && (cnt_rd_i || lim_rd_i || stat_rd_i)) begin
         if (scb.size() == 0) begin
            errors++;
            $display("FAIL %s: unexpected read, actual %h expected none", "R4", rd_data_o);
         end else begin
            exp_item_t it;
            it = scb.pop_front();
            vectors++;
            if (rd_data_o !== it.val) begin
               errors++;
               $display("FAIL %s: rd_data actual %h expected %h", it.req, rd_data_o, it.val);
            end
         end
      end
      if (rst_n) begin
         if (expire_o) pulses++;
         if (expire_o && prev_exp) begin
            errors++;
            $display("FAIL R7: expire_o wide, actual 2 cycles expected 1");
         end
         prev_exp = expire_o;
      end
   end

   task automatic op(bit lw, bit cr, bit lr, bit sr, bit tk,
                     logic [15:0] wd, logic [15:0] ev, string req);
      @(posedge clk); #2;
      lim_wr_i = lw; cnt_rd_i = cr; lim_rd_i = lr; stat_rd_i = sr;
      tick_i = tk; wr_data_i = wd;
      if (cr || lr || sr) scb.push_back('{val: ev, req: req});
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) op(0, 0, 0, 0, 0, 16'h0, 16'h0, "");
   endtask

   task automatic ticks(int n);
      for (int i = 0; i < n; i++) op(0, 0, 0, 0, 1, 16'h0, 16'h0, "");
   endtask

   task automatic rd_cnt(logic [15:0] ev, string req);  op(0, 1, 0, 0, 0, 0, ev, req); endtask
   task automatic rd_lim(logic [15:0] ev, string req);  op(0, 0, 1, 0, 0, 0, ev, req); endtask
   task automatic rd_stat(logic [15:0] ev, string req); op(0, 0, 0, 1, 0, 0, ev, req); endtask
   task automatic wr_lim(logic [15:0] v);               op(1, 0, 0, 0, 0, v, 0, ""); endtask

   task automatic chk(int act, int ex, string req);
      vectors++;
      if (act != ex) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, ex);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
         $finish;
      end
   endtask

   initial begin
      #(20 * 200000);
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;
      // R1 reset state; status encoding per R9
      chk(int'(expire_o), 0, "R1");
      rd_cnt(16'd1, "R1");
      rd_lim(16'd1, "R1");
      rd_stat(16'h0000, "R1");
      // R2 load and start
      wr_lim(16'd5);
      rd_stat(16'h0001, "R2");
      rd_lim(16'd5, "R6");
      rd_cnt(16'd5, "R6");
      // R3 decrement and hold
      ticks(2);
      idle(1);
      rd_cnt(16'd3, "R3");
      rd_cnt(16'd5, "R4");
      // R4 reload beats tick
      op(0, 1, 0, 0, 1, 0, 16'd5, "R4");
      rd_cnt(16'd5, "R4");
      // R7 expiry
      ticks(5);
      idle(2);
      chk(pulses, 1, "R7");
      rd_stat(16'h0002, "R7");
      rd_cnt(16'd0, "R7");
      rd_stat(16'h0002, "R5");
      ticks(3);
      rd_cnt(16'd5, "R3");
      rd_stat(16'h0002, "R8");
      // R10 limit write beats read and tick
      op(1, 1, 0, 0, 1, 16'd3, 16'd5, "R10");
      rd_stat(16'h0001, "R10");
      rd_cnt(16'd3, "R10");
      // R7 zero limit expires on first tick
      wr_lim(16'd0);
      ticks(1);
      idle(2);
      chk(pulses, 2, "R7");
      rd_stat(16'h0002, "R7");
      // full-scale limit, expired cleared by write (R8)
      wr_lim(16'hFFFF);
      rd_lim(16'hFFFF, "R2");
      ticks(1);
      rd_cnt(16'hFFFE, "R3");
      rd_stat(16'h0001, "R8");
      idle(2);
      chk(scb.size(), 0, "R4");
      chk(pulses, 2, "R7");
      finish_run();
   end
endmodule